// File: doc/BRIEF.md
# Smart Card Pin Control Register

This block is a byte-wide control and status register that lets firmware steer the contact pins of an external smart card interface. It drives and samples the card I/O pad and produces the card clock from a supplied clock source. An external mode input selects one of three modes: automatic, synchronous or bypass. In automatic mode, other logic owns the I/O pad, so the register leaves the pad undriven and its I/O settings have no effect.

In synchronous and bypass modes, firmware picks the I/O direction. When the pin is an output, firmware sets its level. When the pin is an input, firmware reads the pin back. In bypass mode the readback is taken raw from the pad. In synchronous mode it is the pad value, passed through a synchronizer, that was captured on the most recent rising edge of the card clock.

The card clock can be stopped at a programmable idle level. The stop is switched only while the source sits at that level, so no short pulse reaches the card. In bypass mode the level bit drives the card clock pin directly.

Top module: `scpc_pinctl`

## Requirements
- R1: After reset every field is 0. A read at the register address returns 0x00, `io_oe` is 0 and `card_clk_o` follows `card_clk_src`.
- R2: The register answers only at address 0xFE0B. A write there stores bit 5 (I/O value), bit 4 (direction, 1 = input), bit 1 (clock level) and bit 0 (clock stop). Bits 7, 6, 3 and 2 read as 0 and ignore writes. A write at any other address changes nothing, and a read at any other address returns 0x00.
- R3: With `mode_i` at 2'b01 (sync) or 2'b10 (bypass), direction 0 gives `io_oe` = 1 and `io_o` = the stored I/O bit. Direction 1 gives `io_oe` = 0.
- R4: With `mode_i` at 2'b00 or 2'b11 (automatic), `io_oe` is 0 whatever the register holds, and read bit 5 returns the stored I/O bit.
- R5: In bypass mode with direction 1, read bit 5 equals `io_i` in the same cycle, with no register in the path.
- R6: In sync mode with direction 1, read bit 5 holds the synchronized `io_i` value captured at the latest rising edge of `card_clk_o`. Between rising edges it does not change.
- R7: Outside bypass mode, with the clock stop at 0 and in force, `card_clk_o` equals `card_clk_src`.
- R8: Outside bypass mode, a change of the clock stop takes effect only on a clock edge at which `card_clk_src` equals the level bit. While stopped, `card_clk_o` equals the level bit.
- R9: In bypass mode `card_clk_o` equals the level bit, and the clock stop bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not selected) |
| mode_i | input | 2 | 00/11 automatic, 01 sync, 10 bypass |
| card_clk_src | input | 1 | Card clock source |
| card_clk_o | output | 1 | Card clock pin |
| io_i | input | 1 | I/O pad input |
| io_o | output | 1 | I/O pad output value |
| io_oe | output | 1 | I/O pad output enable |

## Verification
A register write that changes the clock stop or the level can land in the same cycle in which the clock source does or does not sit at the idle level. The bench provokes this with a sweep over every mode and every register value. It places the source at the level before the write and moves it to the opposite level afterwards. Each step is judged by comparing `card_clk_o` with the level or the source, as the stop and mode settings dictate. The sync readback is judged separately: the pad value is changed while the card clock is held high, and the captured bit must stay put until the next rising edge.

// File: rtl/scpc_pkg.sv
package scpc_pkg;
    typedef enum logic [1:0] {
        MODE_AUTO = 2'b00,
        MODE_SYNC = 2'b01,
        MODE_BYP  = 2'b10,
        MODE_RSV  = 2'b11
    } scpc_mode_e;

    localparam int POS_IO  = 5;
    localparam int POS_DIR = 4;
    localparam int POS_LVL = 1;
    localparam int POS_OFF = 0;

    typedef struct packed {
        logic io;        // stored I/O output value
        logic dir;       // 1 = input
        logic lvl;       // clock idle / bypass level
        logic off;       // clock stop request
        logic gated;     // clock stop in force
        logic clk_prev;  // card clock one cycle ago
        logic samp;      // sync-mode captured pad value
    } scpc_state_t;
endpackage

// File: rtl/scpc_sync.sv
module scpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scpc_clkmux.sv
module scpc_clkmux (
    input  logic bypass,
    input  logic gated,
    input  logic lvl,
    input  logic src,
    input  logic clk_prev,
    output logic clk_o,
    output logic rise
);
    always_comb begin
        if (bypass || gated) clk_o = lvl;
        else                 clk_o = src;
        rise = clk_o & ~clk_prev;
    end
endmodule

// File: rtl/scpc_rdmux.sv
module scpc_rdmux
    import scpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              sel,
    input  scpc_mode_e        mode,
    input  logic              io_reg,
    input  logic              dir,
    input  logic              lvl,
    input  logic              off,
    input  logic              samp,
    input  logic              io_raw,
    output logic [DATA_W-1:0] rdata
);
    logic io_view;

    always_comb begin
        io_view = io_reg;
        if (dir) begin
            if (mode == MODE_BYP)       io_view = io_raw;
            else if (mode == MODE_SYNC) io_view = samp;
        end
        rdata = '0;
        if (sel) begin
            rdata[POS_IO]  = io_view;
            rdata[POS_DIR] = dir;
            rdata[POS_LVL] = lvl;
            rdata[POS_OFF] = off;
        end
    end
endmodule

// File: rtl/scpc_pinctl.sv
module scpc_pinctl
    import scpc_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter logic [15:0] REG_ADDR    = 16'hFE0B,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        mode_i,
    input  logic              card_clk_src,
    output logic              card_clk_o,
    input  logic              io_i,
    output logic              io_o,
    output logic              io_oe
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    scpc_state_t st_d, st_q;
    scpc_mode_e  mode;
    logic        addr_hit, wr_hit, rd_hit;
    logic        io_s, clk_rise, is_byp;

    assign mode     = scpc_mode_e'(mode_i);
    assign addr_hit = (bus_addr == HIT_ADDR);
    assign wr_hit   = bus_wr && addr_hit;
    assign rd_hit   = bus_rd && addr_hit;
    assign is_byp   = (mode == MODE_BYP);

    scpc_sync #(.STAGES(SYNC_STAGES)) i_io_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (io_i),
        .q     (io_s)
    );

    scpc_clkmux i_clkmux (
        .bypass   (is_byp),
        .gated    (st_q.gated),
        .lvl      (st_q.lvl),
        .src      (card_clk_src),
        .clk_prev (st_q.clk_prev),
        .clk_o    (card_clk_o),
        .rise     (clk_rise)
    );

    scpc_rdmux #(.DATA_W(DATA_W)) i_rdmux (
        .sel    (rd_hit),
        .mode   (mode),
        .io_reg (st_q.io),
        .dir    (st_q.dir),
        .lvl    (st_q.lvl),
        .off    (st_q.off),
        .samp   (st_q.samp),
        .io_raw (io_i),
        .rdata  (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.io  = bus_wdata[POS_IO];
            st_d.dir = bus_wdata[POS_DIR];
            st_d.lvl = bus_wdata[POS_LVL];
            st_d.off = bus_wdata[POS_OFF];
        end
        // stop state flips only while the source rests at the idle level
        if (card_clk_src == st_q.lvl) st_d.gated = st_q.off;
        st_d.clk_prev = card_clk_o;
        if (clk_rise) st_d.samp = io_s;

        io_oe = ((mode == MODE_SYNC) || (mode == MODE_BYP)) && !st_q.dir;
        io_o  = st_q.io;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scpc_pinctl_chk.sv
module scpc_pinctl_chk
    import scpc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       card_clk_src,
    input logic       card_clk_o,
    input logic       io_o,
    input logic       io_oe,
    input logic [7:0] bus_rdata,
    input logic       io_reg,
    input logic       dir,
    input logic       lvl,
    input logic       off,
    input logic       gated
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:6] == 2'b00) && (bus_rdata[3:2] == 2'b00));

    // R3
    pad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_SYNC || mode_i == MODE_BYP) && !dir) |-> (io_oe && io_o == io_reg));

    // R4
    auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_AUTO || mode_i == MODE_RSV) |-> !io_oe);

    // R7
    clk_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_BYP && !gated) |-> (card_clk_o == card_clk_src));

    // R8
    gate_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated != $past(gated)) |-> ($past(card_clk_src) == $past(lvl) && gated == $past(off)));

    // R9
    bypass_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_BYP) |-> (card_clk_o == lvl));
endmodule

bind scpc_pinctl scpc_pinctl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .card_clk_src (card_clk_src),
    .card_clk_o   (card_clk_o),
    .io_o         (io_o),
    .io_oe        (io_oe),
    .bus_rdata    (bus_rdata),
    .io_reg       (st_q.io),
    .dir          (st_q.dir),
    .lvl          (st_q.lvl),
    .off          (st_q.off),
    .gated        (st_q.gated)
);

// File: tb/test_scpc_pinctl.sv
module test_scpc_pinctl;
    localparam logic [15:0] RA = 16'hFE0B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  mode_i = 2'b00;
    logic        card_clk_src = 1'b0;
    logic        card_clk_o;
    logic        io_i = 1'b0;
    logic        io_o, io_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    scpc_pinctl i_scpc_pinctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_i(mode_i), .card_clk_src(card_clk_src), .card_clk_o(card_clk_o),
        .io_i(io_i), .io_o(io_o), .io_oe(io_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        logic [7:0] r;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(RA, r);
        chk(r == 8'h00, "R1 reset read", r, 0);
        chk(io_oe == 1'b0, "R1 reset io_oe", io_oe, 0);
        card_clk_src = 1'b1; #1;
        chk(card_clk_o == 1'b1, "R1 reset clock follows", card_clk_o, 1);
        card_clk_src = 1'b0;

        // R2 reserved bits and address decode
        wr(RA, 8'hFF);
        rd(RA, r);
        chk(r == 8'h33, "R2 reserved bits", r, 8'h33);
        wr(RA + 16'd1, 8'h00);
        rd(RA, r);
        chk(r == 8'h33, "R2 other address write ignored", r, 8'h33);
        bus_addr = RA - 16'd1; bus_rd = 1'b1; #1 r = bus_rdata; bus_rd = 1'b0;
        chk(r == 8'h00, "R2 other address read", r, 0);
        wr(RA, 8'h00);
        wait_cyc(2);

        // R5 raw bypass readback
        mode_i = 2'b10;
        wr(RA, 8'h10);
        io_i = 1'b1;
        rd(RA, r);
        chk(r[5] == 1'b1, "R5 bypass raw high", r[5], 1);
        io_i = 1'b0;
        rd(RA, r);
        chk(r[5] == 1'b0, "R5 bypass raw low", r[5], 0);

        // R6 sync capture on card clock rising edge
        mode_i = 2'b01;
        card_clk_src = 1'b0;
        wr(RA, 8'h10);
        io_i = 1'b1;
        wait_cyc(4);
        card_clk_src = 1'b1;
        wait_cyc(2);
        rd(RA, r);
        chk(r[5] == 1'b1, "R6 captured at rise", r[5], 1);
        io_i = 1'b0;
        wait_cyc(4);
        rd(RA, r);
        chk(r[5] == 1'b1, "R6 held while high", r[5], 1);
        card_clk_src = 1'b0;
        wait_cyc(2);
        rd(RA, r);
        chk(r[5] == 1'b1, "R6 held on fall", r[5], 1);
        card_clk_src = 1'b1;
        wait_cyc(2);
        rd(RA, r);
        chk(r[5] == 1'b0, "R6 next rise", r[5], 0);

        // R8 stop switched only at the idle level
        card_clk_src = 1'b1;
        wr(RA, 8'h01);           // level 0, stop
        wait_cyc(2);
        chk(card_clk_o == 1'b1, "R8 stop waits for level", card_clk_o, 1);
        card_clk_src = 1'b0;
        wait_cyc(1);
        card_clk_src = 1'b1; #1;
        chk(card_clk_o == 1'b0, "R8 stopped at level", card_clk_o, 0);
        wr(RA, 8'h00);           // release while source away from level
        wait_cyc(2);
        chk(card_clk_o == 1'b0, "R8 release waits for level", card_clk_o, 0);
        card_clk_src = 1'b0;
        wait_cyc(1);
        card_clk_src = 1'b1; #1;
        chk(card_clk_o == 1'b1, "R8 released follows", card_clk_o, 1);

        // sweep: every mode, register value and pad input
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 16; v++) begin
                for (int x = 0; x < 2; x++) begin
                    logic dir, io, lvl, off, byp, drv, e5;
                    logic [7:0] wd, ex;
                    dir = v[3]; io = v[2]; lvl = v[1]; off = v[0];
                    byp = (m == 2);
                    drv = ((m == 1) || (m == 2)) && !dir;
                    wd  = {2'b00, io, dir, 2'b00, lvl, off};
                    mode_i = 2'(m);
                    io_i = x[0];
                    card_clk_src = lvl;
                    wr(RA, wd);
                    wait_cyc(2);
                    // R3 / R4 pad drive
                    if (m == 1 || m == 2)
                        chk(io_oe == drv, "R3 io_oe", io_oe, drv);
                    else
                        chk(io_oe == 1'b0, "R4 auto io_oe", io_oe, 0);
                    if (drv) chk(io_o == io, "R3 io_o", io_o, io);
                    // readback
                    e5 = io;
                    if (dir && m == 2) e5 = x[0];
                    ex = {2'b00, e5, dir, 2'b00, lvl, off};
                    rd(RA, r);
                    if (dir && m == 1)
                        chk((r & 8'hDF) == (ex & 8'hDF), "R2 sweep readback", r, ex);
                    else if (dir && m == 2)
                        chk(r == ex, "R5 sweep readback", r, ex);
                    else
                        chk(r == ex, "R4 sweep readback", r, ex);
                    chk(card_clk_o == lvl, "R7 clock at level", card_clk_o, lvl);
                    // source moves away from level
                    card_clk_src = ~lvl;
                    wait_cyc(1);
                    if (byp)
                        chk(card_clk_o == lvl, "R9 bypass level", card_clk_o, lvl);
                    else if (off)
                        chk(card_clk_o == lvl, "R8 stopped", card_clk_o, lvl);
                    else
                        chk(card_clk_o == ~lvl, "R7 passes source", card_clk_o, ~lvl);
                end
            end
        end

        done = 1'b1;
        summary();
    end
endmodule